// File: doc/BRIEF.md
# Tagged Multi-Source Memory Request Merger

This block collects memory requests from a command-parser port and from `NUM_CORES` processor-core ports and sends them out as one request stream toward a shared memory controller. Each request it forwards carries a channel tag. The response path uses this tag to route the answer back to the requester that issued it.

Every core works inside its own slice of the shared memory. The core's index is placed above its local address to form the full address. The command parser has no prefix, so it can reach the entire address range.

All ports use a valid/ready handshake, and either side may stall for any number of cycles. A request is moved to the output in the same cycle the downstream side accepts it. The parameter `POLICY` selects the arbitration policy:

- round-robin, which is the default;
- fixed priority.

Top module: `tagged_req_merge`

## Requirements
- R1: `mem_tag_o` is `$clog2(NUM_CORES+1)` bits wide. Tag value 0 marks the command-parser port, and value k+1 marks core port k.
- R2: A request granted from core k leaves with `mem_addr_o = {k, core address}`. The index k fills the upper `PFX_W` bits, and the core's `CORE_AW`-bit address fills the lower bits.
- R3: A request granted from the command-parser port leaves with its full `ADDR_W`-bit address unchanged.
- R4: At most one input ready is high in a cycle. An input ready is high only when `mem_valid_o` and `mem_ready_i` are both high, and only for the input whose request is on the output.
- R5: While `mem_valid_o` is high and `mem_ready_i` is low, the next cycle shows the same request and tag. A request that arrives in the meantime does not take the grant, even if it has higher priority.
- R6: In the round-robin policy, after channel c is accepted, the next grant goes to the first requesting channel in the order c+1, c+2, …, counted modulo `NUM_CORES+1`. Channel numbers are equal to tag values.
- R7: In the fixed-priority policy, the requesting channel with the lowest tag value is granted.
- R8: With no input valid, `mem_valid_o` is low and every input ready is low.
- R9: The write-enable and write data of the granted request are forwarded unchanged.
- R10: After reset, the round-robin search starts at channel 0, so a first cycle in which every input requests grants tag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command-parser request valid |
| cmd_ready_o | output | 1 | Command-parser request accepted |
| cmd_addr_i | input | ADDR_W | Command-parser full address |
| cmd_we_i | input | 1 | Command-parser write enable |
| cmd_wdata_i | input | DATA_W | Command-parser write data |
| core_valid_i | input | NUM_CORES | Per-core request valid |
| core_ready_o | output | NUM_CORES | Per-core request accepted |
| core_addr_i | input | NUM_CORES*CORE_AW | Per-core local addresses; core k sits at bits k*CORE_AW upward |
| core_we_i | input | NUM_CORES | Per-core write enable |
| core_wdata_i | input | NUM_CORES*DATA_W | Per-core write data; core k sits at bits k*DATA_W upward |
| mem_valid_o | output | 1 | Merged request valid |
| mem_ready_i | input | 1 | Downstream accepts the merged request |
| mem_addr_o | output | ADDR_W | Merged address, after relocation |
| mem_we_o | output | 1 | Merged write enable |
| mem_wdata_o | output | DATA_W | Merged write data |
| mem_tag_o | output | TAG_W | Source channel of the merged request |

## Verification
The hardest case to reach from the ports is a downstream stall during which a higher-priority request shows up. In that case the held grant must win over a fresh round-robin decision. The bench produces it in three steps:

1. It parks the rotation pointer on the last core.
2. It raises a single core request with `mem_ready_i` low.
3. It raises the command-parser request in the next cycle, while the stall continues.

In the same setup, the pointer rotation is swept over every starting channel and every non-empty request pattern. The fixed-priority variant is driven from the same inputs.

// File: rtl/req_merge_pkg.sv
package req_merge_pkg;
  typedef enum logic [0:0] {
    ARB_ROUND_ROBIN = 1'b0,
    ARB_FIXED_PRIO  = 1'b1
  } arb_policy_e;
endpackage

// File: rtl/grant_select.sv
module grant_select #(
  parameter int CH = 4,
  parameter req_merge_pkg::arb_policy_e POLICY = req_merge_pkg::ARB_ROUND_ROBIN,
  localparam int IW = $clog2(CH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CH-1:0] req_i,
  input  logic          dn_ready_i,
  output logic          busy_o,
  output logic [IW-1:0] idx_o,
  output logic [CH-1:0] gnt_o
);
  logic          hold_q;
  logic [IW-1:0] held_q;
  logic [IW-1:0] pick_idx;
  logic          pick_any;

  generate
    if (POLICY == req_merge_pkg::ARB_ROUND_ROBIN) begin : g_rr
      logic [IW-1:0] last_q;
      always_comb begin
        int c;
        c = 0;
        pick_any = 1'b0;
        pick_idx = '0;
        for (int off = 1; off <= CH; off++) begin
          c = (int'(last_q) + off) % CH;
          if (!pick_any && req_i[c]) begin
            pick_any = 1'b1;
            pick_idx = IW'(c);
          end
        end
      end
      // Pointer starts on the last channel so channel 0 is searched first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   last_q <= IW'(CH - 1);
        else if (busy_o && dn_ready_i) last_q <= idx_o;
      end
    end else begin : g_fixed
      always_comb begin
        pick_any = |req_i;
        pick_idx = '0;
        for (int c = CH - 1; c >= 0; c--) begin
          if (req_i[c]) pick_idx = IW'(c);
        end
      end
    end
  endgenerate

  assign busy_o = hold_q | pick_any;
  assign idx_o  = hold_q ? held_q : pick_idx;

  for (genvar g = 0; g < CH; g++) begin : g_gnt
    assign gnt_o[g] = busy_o && (idx_o == IW'(g));
  end

  // Freeze the choice while downstream stalls
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      held_q <= '0;
    end else begin
      hold_q <= busy_o & ~dn_ready_i;
      if (busy_o && !dn_ready_i) held_q <= idx_o;
    end
  end
endmodule

// File: rtl/chan_payload.sv
module chan_payload #(
  parameter int NUM_CORES = 3,
  parameter int CORE_AW   = 4,
  parameter int DATA_W    = 8,
  localparam int CH       = NUM_CORES + 1,
  localparam int IW       = $clog2(CH),
  localparam int PFX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int ADDR_W   = CORE_AW + PFX_W
) (
  input  logic [ADDR_W-1:0]              cmd_addr_i,
  input  logic                           cmd_we_i,
  input  logic [DATA_W-1:0]              cmd_wdata_i,
  input  logic [NUM_CORES*CORE_AW-1:0]   core_addr_i,
  input  logic [NUM_CORES-1:0]           core_we_i,
  input  logic [NUM_CORES*DATA_W-1:0]    core_wdata_i,
  input  logic [IW-1:0]                  sel_i,
  output logic [ADDR_W-1:0]              addr_o,
  output logic                           we_o,
  output logic [DATA_W-1:0]              wdata_o
);
  logic [ADDR_W-1:0] ch_addr  [CH];
  logic              ch_we    [CH];
  logic [DATA_W-1:0] ch_wdata [CH];

  assign ch_addr[0]  = cmd_addr_i;
  assign ch_we[0]    = cmd_we_i;
  assign ch_wdata[0] = cmd_wdata_i;

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
    // Relocate core k into its own region
    assign ch_addr[k+1]  = {PFX_W'(k), core_addr_i[k*CORE_AW +: CORE_AW]};
    assign ch_we[k+1]    = core_we_i[k];
    assign ch_wdata[k+1] = core_wdata_i[k*DATA_W +: DATA_W];
  end

  always_comb begin
    addr_o  = ch_addr[0];
    we_o    = ch_we[0];
    wdata_o = ch_wdata[0];
    for (int c = 1; c < CH; c++) begin
      if (sel_i == IW'(c)) begin
        addr_o  = ch_addr[c];
        we_o    = ch_we[c];
        wdata_o = ch_wdata[c];
      end
    end
  end
endmodule

// File: rtl/tagged_req_merge.sv
module tagged_req_merge #(
  parameter int NUM_CORES = 3,
  parameter int CORE_AW   = 4,
  parameter int DATA_W    = 8,
  parameter req_merge_pkg::arb_policy_e POLICY = req_merge_pkg::ARB_ROUND_ROBIN,
  localparam int CH       = NUM_CORES + 1,
  localparam int TAG_W    = $clog2(CH),
  localparam int PFX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int ADDR_W   = CORE_AW + PFX_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cmd_valid_i,
  output logic                         cmd_ready_o,
  input  logic [ADDR_W-1:0]            cmd_addr_i,
  input  logic                         cmd_we_i,
  input  logic [DATA_W-1:0]            cmd_wdata_i,
  input  logic [NUM_CORES-1:0]         core_valid_i,
  output logic [NUM_CORES-1:0]         core_ready_o,
  input  logic [NUM_CORES*CORE_AW-1:0] core_addr_i,
  input  logic [NUM_CORES-1:0]         core_we_i,
  input  logic [NUM_CORES*DATA_W-1:0]  core_wdata_i,
  output logic                         mem_valid_o,
  input  logic                         mem_ready_i,
  output logic [ADDR_W-1:0]            mem_addr_o,
  output logic                         mem_we_o,
  output logic [DATA_W-1:0]            mem_wdata_o,
  output logic [TAG_W-1:0]             mem_tag_o
);
  logic [CH-1:0]    req;
  logic [CH-1:0]    gnt;
  logic [TAG_W-1:0] sel;
  logic             busy;

  assign req = {core_valid_i, cmd_valid_i};

  grant_select #(.CH(CH), .POLICY(POLICY)) u_grant (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req),
    .dn_ready_i (mem_ready_i),
    .busy_o     (busy),
    .idx_o      (sel),
    .gnt_o      (gnt)
  );

  chan_payload #(.NUM_CORES(NUM_CORES), .CORE_AW(CORE_AW), .DATA_W(DATA_W)) u_payload (
    .cmd_addr_i   (cmd_addr_i),
    .cmd_we_i     (cmd_we_i),
    .cmd_wdata_i  (cmd_wdata_i),
    .core_addr_i  (core_addr_i),
    .core_we_i    (core_we_i),
    .core_wdata_i (core_wdata_i),
    .sel_i        (sel),
    .addr_o       (mem_addr_o),
    .we_o         (mem_we_o),
    .wdata_o      (mem_wdata_o)
  );

  assign mem_valid_o  = busy;
  assign mem_tag_o    = sel;
  assign cmd_ready_o  = gnt[0] & mem_ready_i;
  assign core_ready_o = gnt[CH-1:1] & {NUM_CORES{mem_ready_i}};
endmodule

// File: rtl/tagged_req_merge_chk.sv
module tagged_req_merge_chk #(
  parameter int NUM_CORES = 3,
  parameter int CORE_AW   = 4,
  parameter int DATA_W    = 8,
  localparam int CH       = NUM_CORES + 1,
  localparam int TAG_W    = $clog2(CH),
  localparam int PFX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int ADDR_W   = CORE_AW + PFX_W
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         cmd_valid_i,
  input logic                         cmd_ready_o,
  input logic [ADDR_W-1:0]            cmd_addr_i,
  input logic                         cmd_we_i,
  input logic [DATA_W-1:0]            cmd_wdata_i,
  input logic [NUM_CORES-1:0]         core_valid_i,
  input logic [NUM_CORES-1:0]         core_ready_o,
  input logic [NUM_CORES*CORE_AW-1:0] core_addr_i,
  input logic                         mem_valid_o,
  input logic                         mem_ready_i,
  input logic [ADDR_W-1:0]            mem_addr_o,
  input logic                         mem_we_o,
  input logic [DATA_W-1:0]            mem_wdata_o,
  input logic [TAG_W-1:0]             mem_tag_o
);
  p_tag_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (int'(mem_tag_o) < CH));

  p_ready_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({core_ready_o, cmd_ready_o}));

  p_ready_needs_dn_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ready_o || (|core_ready_o)) |-> (mem_valid_o && mem_ready_i));

  p_cmd_passthru_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (mem_tag_o == '0 && mem_addr_o == cmd_addr_i &&
                     mem_we_o == cmd_we_i && mem_wdata_o == cmd_wdata_i));

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_core_chk
    p_core_reloc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      core_ready_o[k] |-> (mem_tag_o == TAG_W'(k + 1) &&
        mem_addr_o == {PFX_W'(k), core_addr_i[k*CORE_AW +: CORE_AW]}));
  end

  p_stall_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_tag_o) &&
      $stable(mem_addr_o) && $stable(mem_wdata_o) && $stable(mem_we_o)));

  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_i || (|core_valid_i)) |-> !mem_valid_o);
endmodule

bind tagged_req_merge tagged_req_merge_chk #(
  .NUM_CORES (NUM_CORES),
  .CORE_AW   (CORE_AW),
  .DATA_W    (DATA_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_ready_o  (cmd_ready_o),
  .cmd_addr_i   (cmd_addr_i),
  .cmd_we_i     (cmd_we_i),
  .cmd_wdata_i  (cmd_wdata_i),
  .core_valid_i (core_valid_i),
  .core_ready_o (core_ready_o),
  .core_addr_i  (core_addr_i),
  .mem_valid_o  (mem_valid_o),
  .mem_ready_i  (mem_ready_i),
  .mem_addr_o   (mem_addr_o),
  .mem_we_o     (mem_we_o),
  .mem_wdata_o  (mem_wdata_o),
  .mem_tag_o    (mem_tag_o)
);

// File: tb/tagged_req_merge_bench.sv
module tagged_req_merge_bench;
  localparam int NC = 3;
  localparam int CAW = 4;
  localparam int DW = 8;
  localparam int AW = 6;
  localparam int TW = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic          cmd_valid, mem_ready;
  logic [AW-1:0] cmd_addr;
  logic          cmd_we;
  logic [DW-1:0] cmd_wdata;
  logic [NC-1:0] core_valid, core_we;
  logic [NC*CAW-1:0] core_addr;
  logic [NC*DW-1:0]  core_wdata;

  logic          rr_cmd_rdy, fx_cmd_rdy, rr_vld, fx_vld, rr_we, fx_we;
  logic [NC-1:0] rr_core_rdy, fx_core_rdy;
  logic [AW-1:0] rr_addr, fx_addr;
  logic [DW-1:0] rr_wd, fx_wd;
  logic [TW-1:0] rr_tag, fx_tag;

  int n_chk = 0;
  int n_fail = 0;

  tagged_req_merge #(.NUM_CORES(NC), .CORE_AW(CAW), .DATA_W(DW),
    .POLICY(req_merge_pkg::ARB_ROUND_ROBIN)) u_tagged_req_merge (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(rr_cmd_rdy), .cmd_addr_i(cmd_addr),
    .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wdata),
    .core_valid_i(core_valid), .core_ready_o(rr_core_rdy), .core_addr_i(core_addr),
    .core_we_i(core_we), .core_wdata_i(core_wdata),
    .mem_valid_o(rr_vld), .mem_ready_i(mem_ready), .mem_addr_o(rr_addr),
    .mem_we_o(rr_we), .mem_wdata_o(rr_wd), .mem_tag_o(rr_tag));

  tagged_req_merge #(.NUM_CORES(NC), .CORE_AW(CAW), .DATA_W(DW),
    .POLICY(req_merge_pkg::ARB_FIXED_PRIO)) u_tagged_req_merge_fix (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(fx_cmd_rdy), .cmd_addr_i(cmd_addr),
    .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wdata),
    .core_valid_i(core_valid), .core_ready_o(fx_core_rdy), .core_addr_i(core_addr),
    .core_we_i(core_we), .core_wdata_i(core_wdata),
    .mem_valid_o(fx_vld), .mem_ready_i(mem_ready), .mem_addr_o(fx_addr),
    .mem_we_o(fx_we), .mem_wdata_o(fx_wd), .mem_tag_o(fx_tag));

  localparam int CMD_A = 6'h2D;
  function automatic int core_a(int k); return (k * 5 + 3) & 15; endfunction
  function automatic int ch_wd(int c); return (8'h40 + c * 17) & 255; endfunction
  function automatic int ch_we(int c); return c & 1; endfunction

  function automatic int exp_rr(int p, int s);
    for (int off = 1; off <= NC + 1; off++) begin
      if (p[(s + off) % (NC + 1)]) return (s + off) % (NC + 1);
    end
    return -1;
  endfunction
  function automatic int exp_fx(int p);
    for (int c = 0; c <= NC; c++) if (p[c]) return c;
    return -1;
  endfunction

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected outputs for a grant to channel g with mem_ready high
  task automatic expect_grant(input string ctx, input bit fx, input int g);
    int ea, crdy, krdy;
    ea   = (g == 0) ? CMD_A : (((g - 1) << CAW) | core_a(g - 1));
    crdy = (g == 0) ? 1 : 0;
    krdy = (g == 0) ? 0 : (1 << (g - 1));
    chk_eq({ctx, " valid"}, fx ? fx_vld : rr_vld, 1);
    chk_eq({ctx, " R1 tag"}, fx ? fx_tag : rr_tag, g);
    chk_eq({ctx, (g == 0) ? " R3 addr" : " R2 addr"}, fx ? fx_addr : rr_addr, ea);
    chk_eq({ctx, " R9 wdata"}, fx ? fx_wd : rr_wd, ch_wd(g));
    chk_eq({ctx, " R9 we"}, fx ? fx_we : rr_we, ch_we(g));
    chk_eq({ctx, " R4 cmd_ready"}, fx ? fx_cmd_rdy : rr_cmd_rdy, crdy);
    chk_eq({ctx, " R4 core_ready"}, fx ? fx_core_rdy : rr_core_rdy, krdy);
  endtask

  task automatic drive(input int p, input bit rdy);
    cmd_valid  = p[0];
    core_valid = p[NC:1];
    mem_ready  = rdy;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cmd_addr  = AW'(CMD_A);
    cmd_we    = 1'(ch_we(0));
    cmd_wdata = DW'(ch_wd(0));
    for (int k = 0; k < NC; k++) begin
      core_addr[k*CAW +: CAW] = CAW'(core_a(k));
      core_we[k]              = 1'(ch_we(k + 1));
      core_wdata[k*DW +: DW]  = DW'(ch_wd(k + 1));
    end
    drive(0, 1'b0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R8 and R10: idle after reset
    @(negedge clk); #1;
    chk_eq("R8 idle valid", rr_vld, 0);
    chk_eq("R8 idle readies", {rr_cmd_rdy, rr_core_rdy, fx_cmd_rdy, fx_core_rdy}, 0);

    // R10: first all-request grant after reset is tag 0
    @(negedge clk); drive(4'hF, 1'b1); #1;
    expect_grant("R10", 1'b0, 0);

    // R6 / R7 sweep: every start channel, every non-empty pattern
    for (int s = 0; s <= NC; s++) begin
      for (int p = 1; p < (1 << (NC + 1)); p++) begin
        @(negedge clk); drive(1 << s, 1'b1);
        @(negedge clk); drive(p, 1'b1); #1;
        expect_grant($sformatf("R6 s=%0d p=%0d", s, p), 1'b0, exp_rr(p, s));
        expect_grant($sformatf("R7 p=%0d", p), 1'b1, exp_fx(p));
      end
    end

    // R5: park pointer on last core, stall a core-1 request, then raise cmd
    @(negedge clk); drive(1 << NC, 1'b1);
    @(negedge clk); drive(4'b0100, 1'b0); #1;
    chk_eq("R5 stall valid", rr_vld, 1);
    chk_eq("R5 stall tag", rr_tag, 2);
    chk_eq("R4 no ready on stall", {rr_cmd_rdy, rr_core_rdy}, 0);
    @(negedge clk); drive(4'b0101, 1'b0); #1;
    chk_eq("R5 held tag rr", rr_tag, 2);
    chk_eq("R5 held tag fix", fx_tag, 2);
    chk_eq("R5 held addr rr", rr_addr, (1 << CAW) | core_a(1));
    @(negedge clk); drive(4'b0101, 1'b0); #1;
    chk_eq("R5 still held rr", rr_tag, 2);
    @(negedge clk); drive(4'b0101, 1'b1); #1;
    expect_grant("R5 release rr", 1'b0, 2);
    expect_grant("R5 release fix", 1'b1, 2);
    @(negedge clk); drive(4'b0001, 1'b1); #1;
    expect_grant("R5 after rr", 1'b0, 0);

    // R8: idle again
    @(negedge clk); drive(0, 1'b1); #1;
    chk_eq("R8 idle valid rr", rr_vld, 0);
    chk_eq("R8 idle valid fix", fx_vld, 0);
    chk_eq("R8 idle readies", {rr_cmd_rdy, rr_core_rdy, fx_cmd_rdy, fx_core_rdy}, 0);

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule